// File: doc/BRIEF.md
# Five-Channel Down-Counting Timer

This block holds five independent down-counters behind a small memory-mapped register port. Software picks a tick rate for each channel from two shared 8-bit prescalers and a per-channel power-of-two divider. It then loads a start value through a per-channel count buffer and starts the channel. On each of its ticks the channel counts down. When it reaches zero it raises an interrupt flag, and it then either stops there or reloads from its buffer and runs on.

The register port is a single-cycle bus. A write takes effect on the clock edge where `bus_wr` is high. A read is combinational from `bus_addr`. The control register packs four bits per channel into slots. Slot 1 is left empty, so channels 1 to 4 sit in slots 2 to 5. The last channel has no invert bit, and its reload bit sits one position lower in its slot. The counter width is a parameter and may be 16 or 32 bits. A divider code above 4 acts as code 4.

Top module: `dct_timer`

## Requirements
- R1: After reset, every register reads zero, every counter reads zero and `irq_o` is low.
- R2: The prescale register at 0x00 holds two 8-bit fields. Bits [7:0] pace channels 0 and 1, and bits [15:8] pace channels 2 to 4. A field value p divides the clock by p+1.
- R3: The divider-select register at 0x04 holds a 4-bit code per channel at bits [4c+3:4c]. Code k further divides the prescaled rate by 2^(k+DIV_BASE), where DIV_BASE defaults to 0. The result is one tick every (p+1)·2^(k+DIV_BASE) clocks.
- R4: The control register at 0x08 gives channel c the slot s, where s = 0 for c = 0 and s = c+1 otherwise. In slot s, bit 4s is start, bit 4s+1 is manual load and bit 4s+2 is invert. Bit 4s+3 is auto-reload. Bits [7:4] read zero. For channel 4 the auto-reload bit is bit 22, and bit 23 reads zero, so writing all ones reads back 0x007FFF0F.
- R5: While a channel's manual-load bit is set, the channel copies its count buffer into its counter on every clock and does not count.
- R6: With start set and manual load clear, the counter drops by one on each channel tick. The counter is read at 0x14+12c for channels 0 to 3 and at 0x40 for channel 4.
- R7: Without auto-reload, a counter that has reached zero stays at zero.
- R8: With auto-reload, a running counter at zero loads its count buffer on the next tick, so a buffer value N gives a zero event every N+1 ticks.
- R9: A channel whose start bit is clear keeps its counter value.
- R10: At 0x44, bits [4:0] are the interrupt enables and bit 5+c is the pending flag of channel c. A pending flag is set when channel c's counter steps from 1 to 0 while its enable is set. Writing 1 to a pending bit clears it.
- R11: `irq_o` is high exactly when some channel has both its pending flag and its enable set. Clearing an enable masks the line but leaves the flag.
- R12: Count buffers sit at 0x0C+12c and read back what was written. Compare buffers for channels 0 to 3 sit at 0x10+12c and also read back. Channel 4 has no compare buffer, so a write to 0x40 changes nothing and 0x40 still returns channel 4's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | OR of pending flags whose enable is set |

## Verification
On every clock, the assertions check each channel's counter step against its own control state. They check the buffer copy under manual load, the decrement of one per tick, the hold while stopped and the stop at zero without reload. They also check that a pending flag only rises when its channel was enabled. The directed scenarios show the rest. These cover the control register's irregular slot layout, the tick rates set by the shared prescalers and the dividers (measured as the drop in count over a fixed window), and the reload period. They also cover masking of the interrupt line, clearing by writing ones, and the missing compare buffer at 0x40.

// File: rtl/dct_pkg.sv
package dct_pkg;
   localparam int NCH   = 5;
   localparam int NGRP  = 2;
   localparam int PRE_W = 8;
   localparam int SEL_W = 4;

   localparam int A_SCALE  = 'h00;
   localparam int A_DIVSEL = 'h04;
   localparam int A_CTRL   = 'h08;
   localparam int A_IRQ    = 'h44;

   // control slot: one empty slot follows channel 0
   function automatic int ctrl_slot(input int ch);
      return (ch == 0) ? 0 : ch + 1;
   endfunction

   // the last channel keeps its reload flag one bit lower
   function automatic int reload_bit(input int ch);
      return (ch == NCH - 1) ? 2 : 3;
   endfunction

   function automatic int grp_of(input int ch);
      return (ch < 2) ? 0 : 1;
   endfunction

   function automatic int buf_addr(input int ch);
      return 12 + 12 * ch;
   endfunction

   function automatic int cmp_addr(input int ch);
      return 16 + 12 * ch;
   endfunction

   function automatic int obs_addr(input int ch);
      return (ch == NCH - 1) ? 'h40 : 20 + 12 * ch;
   endfunction
endpackage

// File: rtl/dct_prescale.sv
module dct_prescale #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] limit,
   output logic             pulse
);
   logic [PRE_W-1:0] phase_q;

   // >= lets a lowered limit take effect without a long wrap
   assign pulse = (phase_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= '0;
      else if (pulse)
         phase_q <= '0;
      else
         phase_q <= phase_q + PRE_W'(1);
   end
endmodule

// File: rtl/dct_divider.sv
module dct_divider #(
   parameter int SEL_W    = 4,
   parameter int MAX_EXP  = 4,
   parameter int DIV_BASE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pre_pulse,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int DW = MAX_EXP + DIV_BASE;

   if (MAX_EXP < 1) begin : g_bad_exp
      $error("dct_divider: MAX_EXP must be at least 1");
   end
   if (DIV_BASE != 0 && DIV_BASE != 1) begin : g_bad_base
      $error("dct_divider: DIV_BASE must be 0 or 1");
   end

   logic [DW-1:0] phase_q;
   logic [DW-1:0] mask;

   always_comb begin
      int e;
      e = (int'(sel) > MAX_EXP) ? MAX_EXP : int'(sel);
      e = e + DIV_BASE;
      mask = DW'((64'd1 << e) - 64'd1);
   end

   assign tick = pre_pulse && ((phase_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= '0;
      else if (pre_pulse)
         phase_q <= phase_q + DW'(1);
   end
endmodule

// File: rtl/dct_channel.sv
module dct_channel #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic             manual,
   input  logic             reload,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             zero_evt
);
   logic at_zero;
   assign at_zero  = (count == '0);
   assign zero_evt = start && !manual && tick && (count == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (manual)
         count <= load_val;
      else if (start && tick) begin
         if (!at_zero)
            count <= count - CNT_W'(1);
         else if (reload)
            count <= load_val;
      end
   end
endmodule

// File: rtl/dct_timer.sv
module dct_timer
   import dct_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int DIV_BASE = 0,
   parameter int MAX_EXP  = 4,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   localparam int CTRL_BITS = 4 * (NCH + 1);

   if (CNT_W != 16 && CNT_W != 32) begin : g_bad_cnt
      $error("dct_timer: CNT_W must be 16 or 32");
   end
   if (DATA_W < CNT_W || DATA_W < CTRL_BITS || DATA_W < 2 * NCH) begin : g_bad_data
      $error("dct_timer: DATA_W too narrow");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("dct_timer: ADDR_W too narrow for the map");
   end

   logic [NGRP-1:0][PRE_W-1:0] scale_q;
   logic [NCH-1:0][SEL_W-1:0]  divsel_q;
   logic [NCH-1:0]             start_q, manual_q, reload_q;
   logic [NCH-2:0]             invert_q;
   logic [NCH-1:0][CNT_W-1:0]  cbuf_q;
   logic [NCH-2:0][CNT_W-1:0]  cmp_q;
   logic [NCH-1:0]             en_q, pend_q;
   logic [NCH-1:0][CNT_W-1:0]  cnt_q;
   logic [NCH-1:0]             tick, zero_evt;
   logic [NGRP-1:0]            pre_pulse;
   logic                       irq_wr;

   assign irq_wr = bus_wr && (bus_addr == ADDR_W'(A_IRQ));

   // ---------------- tick generation ----------------
   for (genvar g = 0; g < NGRP; g++) begin : g_pre
      dct_prescale #(.PRE_W(PRE_W)) u_pre (
         .clk   (clk),
         .rst_n (rst_n),
         .limit (scale_q[g]),
         .pulse (pre_pulse[g])
      );
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dct_divider #(
         .SEL_W   (SEL_W),
         .MAX_EXP (MAX_EXP),
         .DIV_BASE(DIV_BASE)
      ) u_div (
         .clk       (clk),
         .rst_n     (rst_n),
         .pre_pulse (pre_pulse[grp_of(c)]),
         .sel       (divsel_q[c]),
         .tick      (tick[c])
      );

      dct_channel #(.CNT_W(CNT_W)) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick[c]),
         .start    (start_q[c]),
         .manual   (manual_q[c]),
         .reload   (reload_q[c]),
         .load_val (cbuf_q[c]),
         .count    (cnt_q[c]),
         .zero_evt (zero_evt[c])
      );
   end

   // ---------------- configuration writes ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scale_q  <= '0;
         divsel_q <= '0;
         start_q  <= '0;
         manual_q <= '0;
         reload_q <= '0;
         invert_q <= '0;
         cbuf_q   <= '0;
         cmp_q    <= '0;
      end else if (bus_wr) begin
         if (bus_addr == ADDR_W'(A_SCALE))
            for (int g = 0; g < NGRP; g++)
               scale_q[g] <= bus_wdata[PRE_W*g +: PRE_W];
         if (bus_addr == ADDR_W'(A_DIVSEL))
            for (int c = 0; c < NCH; c++)
               divsel_q[c] <= bus_wdata[SEL_W*c +: SEL_W];
         if (bus_addr == ADDR_W'(A_CTRL)) begin
            for (int c = 0; c < NCH; c++) begin
               start_q[c]  <= bus_wdata[4*ctrl_slot(c)];
               manual_q[c] <= bus_wdata[4*ctrl_slot(c) + 1];
               reload_q[c] <= bus_wdata[4*ctrl_slot(c) + reload_bit(c)];
            end
            for (int c = 0; c < NCH - 1; c++)
               invert_q[c] <= bus_wdata[4*ctrl_slot(c) + 2];
         end
         for (int c = 0; c < NCH; c++)
            if (bus_addr == ADDR_W'(buf_addr(c)))
               cbuf_q[c] <= bus_wdata[CNT_W-1:0];
         for (int c = 0; c < NCH - 1; c++)
            if (bus_addr == ADDR_W'(cmp_addr(c)))
               cmp_q[c] <= bus_wdata[CNT_W-1:0];
      end
   end

   // ---------------- interrupt enable / pending ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pend_q <= '0;
      end else begin
         if (irq_wr)
            en_q <= bus_wdata[NCH-1:0];
         for (int c = 0; c < NCH; c++) begin
            if (zero_evt[c] && en_q[c])
               pend_q[c] <= 1'b1;
            else if (irq_wr && bus_wdata[NCH + c])
               pend_q[c] <= 1'b0;
         end
      end
   end

   assign irq_o = |(en_q & pend_q);

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(A_SCALE))
         for (int g = 0; g < NGRP; g++)
            bus_rdata[PRE_W*g +: PRE_W] = scale_q[g];
      if (bus_addr == ADDR_W'(A_DIVSEL))
         for (int c = 0; c < NCH; c++)
            bus_rdata[SEL_W*c +: SEL_W] = divsel_q[c];
      if (bus_addr == ADDR_W'(A_CTRL)) begin
         for (int c = 0; c < NCH; c++) begin
            bus_rdata[4*ctrl_slot(c)]                 = start_q[c];
            bus_rdata[4*ctrl_slot(c) + 1]             = manual_q[c];
            bus_rdata[4*ctrl_slot(c) + reload_bit(c)] = reload_q[c];
         end
         for (int c = 0; c < NCH - 1; c++)
            bus_rdata[4*ctrl_slot(c) + 2] = invert_q[c];
      end
      if (bus_addr == ADDR_W'(A_IRQ)) begin
         bus_rdata[NCH-1:0]     = en_q;
         bus_rdata[2*NCH-1:NCH] = pend_q;
      end
      for (int c = 0; c < NCH; c++) begin
         if (bus_addr == ADDR_W'(buf_addr(c)))
            bus_rdata[CNT_W-1:0] = cbuf_q[c];
         if (bus_addr == ADDR_W'(obs_addr(c)))
            bus_rdata[CNT_W-1:0] = cnt_q[c];
      end
      for (int c = 0; c < NCH - 1; c++)
         if (bus_addr == ADDR_W'(cmp_addr(c)))
            bus_rdata[CNT_W-1:0] = cmp_q[c];
   end
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
   parameter int NCH   = 5,
   parameter int CNT_W = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NCH-1:0]            start_q,
   input logic [NCH-1:0]            manual_q,
   input logic [NCH-1:0]            reload_q,
   input logic [NCH-1:0]            tick,
   input logic [NCH-1:0]            en_q,
   input logic [NCH-1:0]            pend_q,
   input logic [NCH-1:0][CNT_W-1:0] cnt_q,
   input logic [NCH-1:0][CNT_W-1:0] cbuf_q
);
   for (genvar c = 0; c < NCH; c++) begin : g_chk
      // R5: manual load copies the buffer on the next edge
      p_manual_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
         manual_q[c] |=> cnt_q[c] == $past(cbuf_q[c]));

      // R6: one step down per tick while running
      p_step_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (start_q[c] && !manual_q[c] && tick[c] && cnt_q[c] != '0)
         |=> cnt_q[c] == CNT_W'($past(cnt_q[c]) - CNT_W'(1)));

      // R7: one-shot channel rests at zero
      p_oneshot_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (start_q[c] && !manual_q[c] && !reload_q[c] && cnt_q[c] == '0)
         |=> cnt_q[c] == '0);

      // R9: stopped channel holds
      p_stopped_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (!start_q[c] && !manual_q[c]) |=> $stable(cnt_q[c]));

      // R10: a flag only rises for an enabled channel
      p_pend_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend_q[c]) |-> $past(en_q[c]));
   end
endmodule

bind dct_timer dct_checker #(.NCH(dct_pkg::NCH), .CNT_W(CNT_W)) u_dct_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_q  (start_q),
   .manual_q (manual_q),
   .reload_q (reload_q),
   .tick     (tick),
   .en_q     (en_q),
   .pend_q   (pend_q),
   .cnt_q    (cnt_q),
   .cbuf_q   (cbuf_q)
);

// File: tb/tb_dct_timer.sv
`timescale 1ns/1ps
module tb_dct_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   dct_timer dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // called just after a falling edge; returns just after the next one
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic t_reset;
      chk_reg("R1 prescale", 8'h00, 32'h0);
      chk_reg("R1 divsel", 8'h04, 32'h0);
      chk_reg("R1 ctrl", 8'h08, 32'h0);
      chk_reg("R1 irq reg", 8'h44, 32'h0);
      chk_reg("R1 count ch0", 8'h14, 32'h0);
      chk_reg("R1 count ch4", 8'h40, 32'h0);
      chk("R1 irq_o", {31'h0, irq_o}, 32'h0);
   endtask

   task automatic t_ctrl_layout;
      wr(8'h08, 32'hFFFF_FFFF);
      chk_reg("R4 ctrl all-ones readback", 8'h08, 32'h007F_FF0F);
      wr(8'h08, 32'h0);
      chk_reg("R4 ctrl cleared", 8'h08, 32'h0);
   endtask

   task automatic t_buffers;
      wr(8'h18, 32'h0000_1234);
      wr(8'h1C, 32'h0000_ABCD);
      chk_reg("R12 count buffer ch1", 8'h18, 32'h0000_1234);
      chk_reg("R12 compare buffer ch1", 8'h1C, 32'h0000_ABCD);
      wr(8'h3C, 32'h77);
      wr(8'h40, 32'h55);
      chk_reg("R12 write to 0x40 ignored", 8'h40, 32'h0);
      chk_reg("R12 count buffer ch4", 8'h3C, 32'h77);
      wr(8'h08, 32'h0020_0000);         // ch4 manual load
      wait_n(1);
      chk_reg("R5 ch4 manual load", 8'h40, 32'h77);
      wr(8'h08, 32'h0);
   endtask

   task automatic t_oneshot;
      logic [31:0] d;
      wr(8'h44, 32'h1);
      wr(8'h0C, 32'd5);
      wr(8'h08, 32'h2);                  // ch0 manual
      wait_n(1);
      chk_reg("R5 loaded value", 8'h14, 32'd5);
      wait_n(1);
      chk_reg("R5 no counting under manual", 8'h14, 32'd5);
      wr(8'h08, 32'h1);                  // ch0 start, one-shot
      chk_reg("R6 start value", 8'h14, 32'd5);
      for (int j = 1; j <= 4; j++) begin
         wait_n(1);
         chk_reg("R6 count down", 8'h14, 32'(5 - j));
      end
      chk("R11 irq low before zero", {31'h0, irq_o}, 32'h0);
      wait_n(1);
      chk_reg("R6 reached zero", 8'h14, 32'd0);
      chk_reg("R10 pending set", 8'h44, 32'h21);
      chk("R11 irq high", {31'h0, irq_o}, 32'h1);
      wait_n(3);
      chk_reg("R7 one-shot stays zero", 8'h14, 32'd0);
      wr(8'h44, 32'h21);
      rd(8'h44, d);
      chk("R10 write-one clear", d, 32'h01);
      chk("R11 irq low after clear", {31'h0, irq_o}, 32'h0);
      wr(8'h08, 32'h0);
   endtask

   task automatic t_reload_ch4;
      logic [31:0] d;
      wr(8'h44, 32'h10);
      wr(8'h3C, 32'd3);
      wr(8'h08, 32'h0020_0000);         // ch4 manual
      wait_n(1);
      wr(8'h08, 32'h0050_0000);         // ch4 start + reload (bit 22)
      chk_reg("R8 start", 8'h40, 32'd3);
      wait_n(3);
      chk_reg("R8 zero", 8'h40, 32'd0);
      chk_reg("R10 ch4 pending", 8'h44, 32'h210);
      wait_n(1);
      chk_reg("R4 R8 reload from bit 22", 8'h40, 32'd3);
      wait_n(1);
      chk_reg("R8 continue", 8'h40, 32'd2);
      wr(8'h08, 32'h0);                  // stop; last step happens on this edge
      rd(8'h40, d);
      chk("R9 value at stop", d, 32'd1);
      wait_n(5);
      chk_reg("R9 held while stopped", 8'h40, 32'd1);
      wr(8'h44, 32'h200);
      chk_reg("R10 ch4 cleared", 8'h44, 32'h0);
   endtask

   task automatic t_rates;
      logic [31:0] a1, a2, b1, b2;
      wr(8'h00, 32'h0000_0002);          // group0 /3, group1 /1
      wr(8'h04, 32'h0000_0210);          // ch1 code1 (/2), ch2 code2 (/4)
      chk_reg("R2 prescale readback", 8'h00, 32'h2);
      chk_reg("R3 divsel readback", 8'h04, 32'h210);
      wr(8'h18, 32'd1000);
      wr(8'h24, 32'd1000);
      wr(8'h08, 32'h0000_2200);          // ch1, ch2 manual
      wait_n(1);
      wr(8'h08, 32'h0000_1100);          // ch1, ch2 start
      wait_n(2);
      rd(8'h20, a1);
      rd(8'h2C, a2);
      wait_n(60);
      rd(8'h20, b1);
      rd(8'h2C, b2);
      chk("R2 R3 ch1 ticks in 60 clocks", a1 - b1, 32'd10);
      chk("R2 R3 ch2 ticks in 60 clocks", a2 - b2, 32'd15);
      wr(8'h08, 32'h0);
   endtask

   task automatic t_masking;
      wr(8'h44, 32'h0);
      wr(8'h30, 32'd2);
      wr(8'h08, 32'h0002_0000);          // ch3 manual
      wait_n(1);
      wr(8'h08, 32'h0001_0000);          // ch3 start, one-shot
      wait_n(4);
      chk_reg("R7 ch3 at zero", 8'h38, 32'd0);
      chk_reg("R10 no pending when disabled", 8'h44, 32'h0);
      chk("R11 irq low when disabled", {31'h0, irq_o}, 32'h0);
      wr(8'h44, 32'h08);
      wr(8'h08, 32'h0009_0000);          // ch3 start + reload
      wait_n(4);
      chk_reg("R10 ch3 pending", 8'h44, 32'h108);
      chk("R11 irq high ch3", {31'h0, irq_o}, 32'h1);
      wr(8'h08, 32'h0);
      wr(8'h44, 32'h0);
      chk_reg("R11 flag kept when masked", 8'h44, 32'h100);
      chk("R11 irq masked", {31'h0, irq_o}, 32'h0);
      wr(8'h44, 32'h100);
      chk_reg("R10 ch3 cleared", 8'h44, 32'h0);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      t_reset();
      t_ctrl_layout();
      t_buffers();
      t_oneshot();
      t_reload_ch4();
      t_rates();
      t_masking();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule